// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a small processor subsystem. It counts the pulses of a slow time-base enable, nominally one every 4 µs. If firmware lets the selected timeout run out, the block asks for a system reset. Firmware services the watchdog through a byte-wide register port. A write strobe and a register address select one of three registers: a key register, a control register and a status register. Reads return the addressed register combinationally.

The control register is guarded. After power-on it ignores writes. Two consecutive key-register writes of 0x1E and then 0xE1 open it. The reverse pair, 0xE1 and then 0x1E, closes it again. The control register holds:
- an enable bit;
- a strobe that restarts the count;
- a 3-bit timeout select. Each step doubles the period, from 2^BASE_LOG2 ticks up to 2^(BASE_LOG2+7) ticks.

On timeout the block raises the reset request for a fixed number of clock cycles. It also disables itself and records the cause in a sticky status flag, which firmware can inspect after the restart.

Top module: `wdg_keyed_top`

## Requirements
- R1: After power-on reset (rst_n low) the control register (address 1) reads 0x00, the status register (address 2) reads 0x00, the key register (address 0) and address 3 read 0x00, sys_rst_req is low and the control register is locked.
- R2: While locked, a write to the control register changes nothing visible: the control readback and the timeout behaviour stay as they were.
- R3: Two consecutive key-register writes, 0x1E then 0xE1, unlock the control register. Writes to other addresses between them do not break the pair. After unlocking, control writes take effect on the next clock edge.
- R4: Two consecutive key-register writes, 0xE1 then 0x1E, made while unlocked, lock the control register again.
- R5: A key write that is not the expected next byte returns the sequence detector to idle, and the lock state does not change. A repeated first byte also counts as a mismatch.
- R6: Control field positions: bit 7 enable, bit 5 count-clear strobe, bits 2:0 timeout select. Bits 6, 5, 4 and 3 always read as 0. Status field: bit 7 is the watchdog-reset flag, and the other bits read 0.
- R7: While enabled, the count advances once per clock edge that sees tick_en high. A timeout occurs on the tick that completes (2^BASE_LOG2 << select) ticks since enabling or since the last clear.
- R8: A control write with bit 5 set zeroes the count in that cycle, so a full period is needed again before a timeout.
- R9: A timeout raises sys_rst_req from the next clock edge for exactly RST_CYC clock cycles.
- R10: A timeout clears the enable bit and sets status bit 7. A timeout takes precedence over a control or status write in the same cycle.
- R11: The status flag stays set until firmware writes the status register with bit 7 at 0, or until power-on reset. Writing bit 7 as 1 leaves it unchanged.
- R12: While disabled, the count is held at zero and no timeout occurs, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | Time-base pulse, one clock wide |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 key, 1 control, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| sys_rst_req | output | 1 | Reset request pulse |

## Verification
Key sequences are tried in four forms: the correct pair, the correct pair with a foreign write between the two bytes, a pair broken by a stray byte, and a pair broken by a repeated first byte. These separate a detector that checks only adjacency from one that treats a repeat as a mismatch. Timeouts are measured one tick short of and exactly at the period, with and without an intervening clear and after a disable. This separates an off-by-one limit, a clear that fails to restart the count, and a count that survives disabling. A seeded random mix of key, control and status writes under a free-running tick is then compared every cycle against a bench model. That mix exposes precedence errors between a timeout and a same-cycle write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W       = 8;
    localparam int ADDR_W       = 2;
    localparam int PS_W         = 3;
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_CLR_BIT  = 5;
    localparam int STS_FLAG_BIT = 7;

    localparam logic [DATA_W-1:0] KEY_BYTE_A = 8'h1E;
    localparam logic [DATA_W-1:0] KEY_BYTE_B = 8'hE1;

    localparam logic [ADDR_W-1:0] ADDR_KEY = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STS = 2'd2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } seq_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic              unlocked
);
    typedef struct packed {
        logic locked;
        seq_e seq;
    } gate_t;

    gate_t gate_d, gate_q;
    logic [DATA_W-1:0] want_first;
    logic [DATA_W-1:0] want_second;

    // the opening pair and the closing pair are mirror images
    assign want_first  = gate_q.locked ? KEY_BYTE_A : KEY_BYTE_B;
    assign want_second = gate_q.locked ? KEY_BYTE_B : KEY_BYTE_A;

    always_comb begin
        gate_d = gate_q;
        if (key_wr) begin
            if (gate_q.seq == SEQ_IDLE) begin
                gate_d.seq = (key_data == want_first) ? SEQ_HALF : SEQ_IDLE;
            end else begin
                gate_d.seq = SEQ_IDLE;
                if (key_data == want_second) begin
                    gate_d.locked = ~gate_q.locked;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '{locked: 1'b1, seq: SEQ_IDLE};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign unlocked = ~gate_q.locked;

    // R5: the lock only moves on a key write
    a_r5_lock_moves_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q.locked != $past(gate_q.locked)) |-> $past(key_wr));
    // R3: opening completes on the second byte of the open pair
    a_r3_open_on_second: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q.locked) |-> ($past(key_data) == KEY_BYTE_B));
    // R4: closing completes on the second byte of the close pair
    a_r4_close_on_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q.locked) |-> ($past(key_data) == KEY_BYTE_A));
endmodule

// File: rtl/wdg_tick_counter.sv
module wdg_tick_counter
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr_stb,
    input  logic            tick_en,
    input  logic [PS_W-1:0] ps_sel,
    output logic            expire
);
    localparam int CNT_W = BASE_LOG2 + (1 << PS_W) - 1;
    localparam int SH_W  = $clog2(CNT_W + 1) + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] last;
    logic [SH_W-1:0]  shamt;
    logic             at_end;

    always_comb begin
        shamt   = SH_W'(BASE_LOG2) + SH_W'(ps_sel);
        span    = {{CNT_W{1'b0}}, 1'b1} << shamt;
        span_m1 = span - {{CNT_W{1'b0}}, 1'b1};
        last    = span_m1[CNT_W-1:0];
    end

    // a shortened select during a run ends the period at once
    assign at_end = (cnt_q >= last);
    assign expire = run && !clr_stb && tick_en && at_end;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || clr_stb) begin
            cnt_d = '0;
        end else if (tick_en) begin
            cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cnt_q == '0));
    a_r7_expire_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));
endmodule

// File: rtl/wdg_rst_stretch.sv
module wdg_rst_stretch #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (fire) begin
            left_d = CW'(RST_CYC);
        end else if (left_q != '0) begin
            left_d = left_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else begin
            left_q <= left_d;
        end
    end

    assign req = (left_q != '0);

    a_r9_req_starts_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(fire));
    a_r9_fire_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 9,
    parameter int RST_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req
);
    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] ps;
        logic            flag;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  key_wr, ctl_wr, sts_wr;
    logic  unlocked, ctl_ok, clr_stb, expire;

    assign key_wr  = bus_wr && (bus_addr == ADDR_KEY);
    assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);
    assign sts_wr  = bus_wr && (bus_addr == ADDR_STS);
    assign ctl_ok  = ctl_wr && unlocked;
    assign clr_stb = ctl_ok && bus_wdata[CTL_CLR_BIT];

    wdg_key_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .unlocked (unlocked)
    );

    wdg_tick_counter #(.BASE_LOG2(BASE_LOG2)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (regs_q.en),
        .clr_stb (clr_stb),
        .tick_en (tick_en),
        .ps_sel  (regs_q.ps),
        .expire  (expire)
    );

    wdg_rst_stretch #(.RST_CYC(RST_CYC)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire),
        .req   (sys_rst_req)
    );

    always_comb begin
        regs_d = regs_q;
        if (ctl_ok) begin
            regs_d.en = bus_wdata[CTL_EN_BIT];
            regs_d.ps = bus_wdata[PS_W-1:0];
        end
        if (expire) begin
            regs_d.en   = 1'b0;
            regs_d.flag = 1'b1;
        end else if (sts_wr && !bus_wdata[STS_FLAG_BIT]) begin
            regs_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTL: begin
                bus_rdata[CTL_EN_BIT] = regs_q.en;
                bus_rdata[PS_W-1:0]   = regs_q.ps;
            end
            ADDR_STS: bus_rdata[STS_FLAG_BIT] = regs_q.flag;
            default:  bus_rdata = '0;
        endcase
    end

    // R10: a timeout disables the watchdog and records the cause
    a_r10_expire_effects: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!regs_q.en && regs_q.flag));
    // R11: the flag only drops through a status write of zero
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.flag) |-> $past(sts_wr && !bus_wdata[STS_FLAG_BIT]));
    // R2: a locked control write leaves the select alone
    a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !unlocked) |=> $stable(regs_q.ps));
endmodule

// File: tb/tb_wdg_keyed_top.sv
module tb_wdg_keyed_top;
    localparam int CLK_PERIOD = 10;
    localparam int B_LOG2     = 3;
    localparam int RST_CYC    = 5;
    localparam int TICK_DIV   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       sys_rst_req;
    logic       tick_run = 1'b0;
    logic       man_tick = 1'b0;
    logic       auto_tick = 1'b0;
    logic       tick_en;
    int         tick_ph = 0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model state
    bit m_locked, m_half, m_en, m_flag;
    int m_ps, m_cnt, m_rc;

    assign tick_en = tick_run ? auto_tick : man_tick;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_keyed_top #(.BASE_LOG2(B_LOG2), .RST_CYC(RST_CYC)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sys_rst_req (sys_rst_req)
    );

    always @(negedge clk) begin
        tick_ph   = (tick_ph + 1) % TICK_DIV;
        auto_tick = (tick_ph == 0);
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        logic [7:0] v;
        v = 8'h00;
        if (a == 2'd1) v = {m_en, 4'b0000, 3'(m_ps)};
        else if (a == 2'd2) v = {m_flag, 7'b0};
        return v;
    endfunction

    function automatic int limit_of(input int ps);
        return (1 << B_LOG2) << ps;
    endfunction

    always @(posedge clk) begin
        bit kw, cw, sw, cok, clr, ex, n_locked, n_half, n_en, n_flag;
        int n_cnt, n_rc, n_ps;
        if (!rst_n) begin
            m_locked = 1; m_half = 0; m_en = 0; m_flag = 0;
            m_ps = 0; m_cnt = 0; m_rc = 0;
        end else begin
            kw  = bus_wr && bus_addr == 2'd0;
            cw  = bus_wr && bus_addr == 2'd1;
            sw  = bus_wr && bus_addr == 2'd2;
            cok = cw && !m_locked;
            clr = cok && bus_wdata[5];
            ex  = m_en && !clr && tick_en && (m_cnt >= limit_of(m_ps) - 1);
            if (!m_en || clr) n_cnt = 0;
            else if (tick_en) n_cnt = ex ? 0 : m_cnt + 1;
            else n_cnt = m_cnt;
            n_rc   = ex ? RST_CYC : (m_rc > 0 ? m_rc - 1 : 0);
            n_flag = ex ? 1'b1 : ((sw && !bus_wdata[7]) ? 1'b0 : m_flag);
            n_en = m_en; n_ps = m_ps;
            if (cok) begin n_en = bus_wdata[7]; n_ps = int'(bus_wdata[2:0]); end
            if (ex) n_en = 1'b0;
            n_locked = m_locked; n_half = m_half;
            if (kw) begin
                if (!m_half) begin
                    n_half = (bus_wdata == (m_locked ? 8'h1E : 8'hE1));
                end else begin
                    n_half = 1'b0;
                    if (bus_wdata == (m_locked ? 8'hE1 : 8'h1E)) n_locked = !m_locked;
                end
            end
            m_locked = n_locked; m_half = n_half; m_en = n_en; m_ps = n_ps;
            m_cnt = n_cnt; m_rc = n_rc; m_flag = n_flag;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model (R7, R9, R10, R11 under random traffic)
    always begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk("R9 model req", {7'b0, sys_rst_req}, {7'b0, m_rc != 0});
            chk("R10 model rdata", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); man_tick = 1'b1;
            @(negedge clk); man_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int hi;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); chk("R1 ctl after reset", v, 8'h00);
        rd(2'd2, v); chk("R1 sts after reset", v, 8'h00);
        rd(2'd0, v); chk("R1 key reads zero", v, 8'h00);
        rd(2'd3, v); chk("R1 spare reads zero", v, 8'h00);
        chk("R1 req low", {7'b0, sys_rst_req}, 8'h00);

        // R2 locked control write
        wr(2'd1, 8'h85);
        rd(2'd1, v); chk("R2 locked write ignored", v, 8'h00);
        ticks(12);
        chk("R2 no timeout while locked", {7'b0, sys_rst_req}, 8'h00);

        // R5 broken sequences
        wr(2'd0, 8'h1E); wr(2'd0, 8'h55); wr(2'd0, 8'hE1);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R5 stray byte keeps lock", v, 8'h00);
        wr(2'd0, 8'h1E); wr(2'd0, 8'h1E); wr(2'd0, 8'hE1);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R5 repeated first byte keeps lock", v, 8'h00);

        // R3 unlock with a foreign write in between
        wr(2'd0, 8'h1E); wr(2'd2, 8'h80); wr(2'd0, 8'hE1);
        wr(2'd1, 8'h03);
        rd(2'd1, v); chk("R3 unlocked write lands", v, 8'h03);

        // R6 field layout
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R6 reserved and clear read zero", v, 8'h87);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R6 cleared back", v, 8'h00);

        // R12 disabled ignores ticks
        ticks(40);
        chk("R12 no timeout when disabled", {7'b0, sys_rst_req}, 8'h00);

        // R7 exact period, select 0 = 8 ticks
        wr(2'd1, 8'h80);
        ticks(7);
        chk("R7 one tick short", {7'b0, sys_rst_req}, 8'h00);
        rd(2'd1, v); chk("R7 still enabled", v, 8'h80);
        ticks(1);
        chk("R9 req on final tick", {7'b0, sys_rst_req}, 8'h01);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            if (sys_rst_req) hi++;
            @(negedge clk);
        end
        chk("R9 pulse length", 8'(hi), 8'(RST_CYC));

        // R10 effects
        rd(2'd1, v); chk("R10 enable cleared", v, 8'h00);
        rd(2'd2, v); chk("R10 flag set", v, 8'h80);

        // R11 writing one keeps, power-on reset clears
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R11 write one keeps flag", v, 8'h80);
        do_reset();
        rd(2'd2, v); chk("R11 power-on clears flag", v, 8'h00);
        wr(2'd1, 8'h81);
        rd(2'd1, v); chk("R1 locked again after reset", v, 8'h00);

        // R4 relock
        wr(2'd0, 8'h1E); wr(2'd0, 8'hE1);
        wr(2'd1, 8'h04);
        wr(2'd0, 8'hE1); wr(2'd0, 8'h1E);
        wr(2'd1, 8'h07);
        rd(2'd1, v); chk("R4 relocked", v, 8'h04);
        wr(2'd0, 8'h1E); wr(2'd0, 8'hE1);

        // R12 re-enable starts from zero after a disabled stretch
        wr(2'd1, 8'h80); ticks(5); wr(2'd1, 8'h00); ticks(3);
        wr(2'd1, 8'h80); ticks(7);
        chk("R12 count restarted after disable", {7'b0, sys_rst_req}, 8'h00);
        wr(2'd1, 8'h00);

        // R8 clear defers timeout, select 1 = 16 ticks
        wr(2'd1, 8'h81); ticks(10);
        wr(2'd1, 8'hA1); ticks(15);
        chk("R8 clear deferred timeout", {7'b0, sys_rst_req}, 8'h00);
        ticks(1);
        chk("R8 timeout after full period", {7'b0, sys_rst_req}, 8'h01);
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R11 write zero clears flag", v, 8'h00);
        repeat (10) @(negedge clk);

        // random traffic under a free-running tick
        tick_run = 1'b1;
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 9);
            if (op <= 3) begin
                @(negedge clk);
                bus_addr = 2'($urandom_range(0, 3));
            end else if (op <= 5) begin
                case ($urandom_range(0, 2))
                    0: d = 8'h1E;
                    1: d = 8'hE1;
                    default: d = 8'($urandom);
                endcase
                wr(2'd0, d);
            end else if (op <= 7) begin
                d = 8'($urandom);
                d[7] = ($urandom_range(0, 4) != 0);
                d[5] = ($urandom_range(0, 5) == 0);
                d[2:0] = 3'($urandom_range(0, 2));
                wr(2'd1, d);
            end else if (op == 8) begin
                wr(2'd2, 8'($urandom));
            end else begin
                wr(2'd3, 8'($urandom));
            end
        end
        tick_run = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule